// File: doc/BRIEF.md
# Bit-Serial Accumulating Adder

This block adds two W-bit operands one bit per clock, using a single full-adder cell and a carry flip-flop instead of a W-bit parallel adder. The augend sits in an accumulator shift register and the addend in a second shift register. On each enabled clock the cell adds the low bits of both registers and the stored carry. The sum bit enters the accumulator at its top, and the new carry is kept for the next bit. In the same clock the addend register shifts right and takes a fresh bit from a serial input, so the next operand is in place when the current addition ends.

Each addition is framed by a start pulse. The start pulse clears the carry and restarts an internal bit counter. After W enabled clocks the accumulator holds the W-bit sum, the carry output holds bit W of the full sum, and a one-cycle done flag is raised. A synchronous clear empties all state. A parallel load writes both operand registers directly. When the accumulator starts from zero, one pass copies the serially refilled addend into it.

Top module: `bit_serial_adder`

## Requirements
- R1: While rst_ni is low, acc_o, carry_o and done_o are 0, and the addend register and the bit counter are 0.
- R2: clr_i high zeroes the accumulator, the addend register, the carry and the bit counter at the next edge, and drops done_o. It takes priority over load_i, start_i and shift_en_i.
- R3: load_i high (without clr_i) writes load_a_i into the accumulator and load_b_i into the addend register at the next edge. No shift happens in that cycle, and the carry keeps its value.
- R4: An enabled shift (shift_en_i high while clr_i, load_i and start_i are low) forms the sum and carry of acc[0], addend[0] and the carry. The sum bit enters accumulator bit W-1 as the accumulator shifts right, and the carry out is stored.
- R5: On each enabled shift the addend register shifts right and ser_i enters its bit W-1. After W shifts, the first serial bit sits at bit 0.
- R6: W enabled shifts after a start leave acc_o equal to (A+B) mod 2^W and carry_o equal to bit W of A+B, where A and B are the register contents at the start.
- R7: With shift_en_i low and clr_i, load_i and start_i low, the accumulator, the addend register and the carry hold their values.
- R8: start_i high (without clr_i) clears the carry and the bit counter, blocks the shift in that cycle, and leaves the accumulator unchanged unless load_i is also high.
- R9: done_o is high for exactly the one cycle after the W-th enabled shift since the last start or clear. Further shifts raise it again only after a new start or clear.
- R10: With the accumulator at 0, a pass of W shifts leaves acc_o equal to the addend and carry_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of all state |
| start_i | input | 1 | Begin a new addition: clear carry and bit counter |
| shift_en_i | input | 1 | Enable one bit step |
| ser_i | input | 1 | Serial bit entering the addend register |
| load_i | input | 1 | Parallel load of both operand registers |
| load_a_i | input | W | Parallel value for the accumulator |
| load_b_i | input | W | Parallel value for the addend register |
| acc_o | output | W | Accumulator contents |
| carry_o | output | 1 | Carry flip-flop |
| done_o | output | 1 | One-cycle pulse after W shifts |

## Verification
The addend register is never visible at the ports, so the serial refill can only be seen through a later addition. The bench runs one addition while it feeds a known serial pattern, starts a second pass with zero serial input, and checks that the pattern was added into the previous sum. The clear-into-copy case, where a zeroed accumulator takes the addend unchanged, is reached the same way. Pauses of shift_en_i in the middle of an addition check that the carry survives a hold.

// File: rtl/sadd_pkg.sv
package sadd_pkg;
  typedef enum logic [1:0] {
    SR_HOLD  = 2'd0,
    SR_CLEAR = 2'd1,
    SR_LOAD  = 2'd2,
    SR_SHIFT = 2'd3
  } sr_op_e;
endpackage

// File: rtl/sadd_fa_cell.sv
module sadd_fa_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = a_i ^ b_i ^ c_i;
  assign c_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
endmodule

// File: rtl/sadd_shreg.sv
module sadd_shreg
  import sadd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  sr_op_e       op_i,
  input  logic [W-1:0] par_i,
  input  logic         msb_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0;
    end else begin
      unique case (op_i)
        SR_CLEAR: q_q <= '0;
        SR_LOAD:  q_q <= par_i;
        SR_SHIFT: q_q <= {msb_i, q_q[W-1:1]};
        default:  q_q <= q_q;
      endcase
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/sadd_bit_cnt.sv
module sadd_bit_cnt #(
  parameter int W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic step_i,
  output logic done_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);
  localparam logic [CW-1:0] FULL = CW'(W);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= step_i && (cnt_q == LAST);
      if (step_i && (cnt_q != FULL)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/bit_serial_adder.sv
module bit_serial_adder
  import sadd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         start_i,
  input  logic         shift_en_i,
  input  logic         ser_i,
  input  logic         load_i,
  input  logic [W-1:0] load_a_i,
  input  logic [W-1:0] load_b_i,
  output logic [W-1:0] acc_o,
  output logic         carry_o,
  output logic         done_o
);
  sr_op_e       op;
  logic [W-1:0] acc_q, addend_q;
  logic         carry_q, sum_bit, carry_nxt, step;

  // clear > load > start-blocked > shift
  always_comb begin
    if (clr_i)                       op = SR_CLEAR;
    else if (load_i)                 op = SR_LOAD;
    else if (shift_en_i && !start_i) op = SR_SHIFT;
    else                             op = SR_HOLD;
  end

  assign step = (op == SR_SHIFT);

  sadd_fa_cell u_fa (
    .a_i(acc_q[0]),
    .b_i(addend_q[0]),
    .c_i(carry_q),
    .s_o(sum_bit),
    .c_o(carry_nxt)
  );

  sadd_shreg #(.W(W)) u_acc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .op_i  (op),
    .par_i (load_a_i),
    .msb_i (sum_bit),
    .q_o   (acc_q)
  );

  sadd_shreg #(.W(W)) u_addend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .op_i  (op),
    .par_i (load_b_i),
    .msb_i (ser_i),
    .q_o   (addend_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              carry_q <= 1'b0;
    else if (clr_i || start_i) carry_q <= 1'b0;
    else if (step)            carry_q <= carry_nxt;
  end

  sadd_bit_cnt #(.W(W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(clr_i || start_i),
    .step_i   (step),
    .done_o   (done_o)
  );

  assign acc_o   = acc_q;
  assign carry_o = carry_q;
endmodule

// File: rtl/bit_serial_adder_chk.sv
module bit_serial_adder_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         clr_i,
  input logic         start_i,
  input logic         shift_en_i,
  input logic         load_i,
  input logic [W-1:0] load_a_i,
  input logic [W-1:0] acc_o,
  input logic         carry_o,
  input logic         done_o
);
  logic quiet, stepping;
  assign quiet    = !clr_i && !load_i && !start_i && !shift_en_i;
  assign stepping = shift_en_i && !clr_i && !load_i && !start_i;

  p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_o == '0) && !carry_o && !done_o);

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> (acc_o == $past(load_a_i)));

  p_shift_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stepping |=> (acc_o[W-2:0] == $past(acc_o[W-1:1])));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet |=> $stable(acc_o) && $stable(carry_o));

  p_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !clr_i) |=> !carry_o);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind bit_serial_adder bit_serial_adder_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clr_i     (clr_i),
  .start_i   (start_i),
  .shift_en_i(shift_en_i),
  .load_i    (load_i),
  .load_a_i  (load_a_i),
  .acc_o     (acc_o),
  .carry_o   (carry_o),
  .done_o    (done_o)
);

// File: tb/sim_bit_serial_adder.sv
module sim_bit_serial_adder;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic clr_i = 0, start_i = 0, shift_en_i = 0, ser_i = 0, load_i = 0;
  logic [W-1:0] load_a_i = '0, load_b_i = '0;
  logic [W-1:0] acc_o;
  logic carry_o, done_o;

  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bit_serial_adder #(.W(W)) u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    clr_i = 0; start_i = 0; shift_en_i = 0; ser_i = 0; load_i = 0;
  endtask

  // load + start in one cycle
  task automatic begin_add(logic [W-1:0] a, logic [W-1:0] b);
    load_i = 1; start_i = 1; load_a_i = a; load_b_i = b;
    @(negedge clk_i); idle();
  endtask

  task automatic shift_n(int n, logic [W-1:0] s, int first);
    for (int i = 0; i < n; i++) begin
      shift_en_i = 1; ser_i = s[first + i];
      @(negedge clk_i);
    end
    idle();
  endtask

  task automatic t_reset();
    chk("R1 acc", acc_o, 0);
    chk("R1 carry", carry_o, 0);
    chk("R1 done", done_o, 0);
  endtask

  task automatic t_add(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] s);
    logic [W:0] sum = {1'b0, a} + {1'b0, b};
    begin_add(a, b);
    chk("R8 carry after start", carry_o, 0);
    chk("R3 load acc", acc_o, a);
    shift_n(W-1, s, 0);
    chk("R9 no early done", done_o, 0);
    shift_n(1, s, W-1);
    chk("R6 sum", acc_o, sum[W-1:0]);
    chk("R6 carry", carry_o, sum[W]);
    chk("R9 done high", done_o, 1);
    @(negedge clk_i);
    chk("R9 done single", done_o, 0);
  endtask

  task automatic t_refill(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] s);
    logic [W:0] sum = {1'b0, a} + {1'b0, b};
    logic [W:0] sum2;
    t_add(a, b, s);
    sum2 = {1'b0, sum[W-1:0]} + {1'b0, s};
    start_i = 1; @(negedge clk_i); idle();
    chk("R8 acc kept on start", acc_o, sum[W-1:0]);
    shift_n(W, '0, 0);
    chk("R5 refill sum", acc_o, sum2[W-1:0]);
    chk("R5 refill carry", carry_o, sum2[W]);
  endtask

  task automatic t_hold(logic [W-1:0] a, logic [W-1:0] b);
    logic [W:0] sum = {1'b0, a} + {1'b0, b};
    logic [W-1:0] acc_snap;
    logic c_snap;
    begin_add(a, b);
    shift_n(3, '0, 0);
    acc_snap = acc_o; c_snap = carry_o;
    ser_i = 1;
    repeat (3) @(negedge clk_i);
    chk("R7 acc held", acc_o, acc_snap);
    chk("R7 carry held", carry_o, c_snap);
    chk("R7 no done", done_o, 0);
    shift_n(W-3, '0, 0);
    chk("R7 sum after pause", acc_o, sum[W-1:0]);
    chk("R7 carry after pause", carry_o, sum[W]);
    chk("R9 done after pause", done_o, 1);
  endtask

  task automatic t_clear_copy(logic [W-1:0] s);
    begin_add(8'hA5, 8'h7E);
    shift_n(4, '0, 0);
    clr_i = 1; load_i = 1; start_i = 1; shift_en_i = 1;
    load_a_i = 8'hFF; load_b_i = 8'hFF;
    @(negedge clk_i); idle();
    chk("R2 acc cleared", acc_o, 0);
    chk("R2 carry cleared", carry_o, 0);
    shift_n(W, s, 0);
    chk("R2 addend was cleared", acc_o, 0);
    chk("R9 done after clear", done_o, 1);
    start_i = 1; @(negedge clk_i); idle();
    shift_n(W, '0, 0);
    chk("R10 copy", acc_o, s);
    chk("R10 carry zero", carry_o, 0);
  endtask

  task automatic t_done_once();
    t_add(8'h12, 8'h34, '0);
    for (int i = 0; i < W + 2; i++) begin
      shift_en_i = 1; @(negedge clk_i);
      chk("R9 no repeat done", done_o, 0);
    end
    idle();
  endtask

  task automatic t_load_carry();
    t_add(8'hFF, 8'h01, '0);
    load_i = 1; load_a_i = 8'h3C; load_b_i = 8'h00; shift_en_i = 1;
    @(negedge clk_i); idle();
    chk("R3 load acc", acc_o, 8'h3C);
    chk("R3 carry kept", carry_o, 1);
    start_i = 1; shift_en_i = 1; @(negedge clk_i); idle();
    chk("R8 start clears carry", carry_o, 0);
    chk("R8 start blocks shift", acc_o, 8'h3C);
  endtask

  task automatic t_step(logic [W-1:0] a, logic [W-1:0] b);
    logic [W:0] p = {1'b0, a[0]} + {1'b0, b[0]};
    begin_add(a, b);
    shift_n(1, '0, 0);
    chk("R4 one step acc", acc_o, {p[0], a[W-1:1]});
    chk("R4 one step carry", carry_o, p[1]);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    @(negedge clk_i);
    t_step(8'h01, 8'h01);
    t_add(8'h3A, 8'h45, 8'h00);
    t_add(8'hFF, 8'h01, 8'h00);
    t_add(8'hC8, 8'h9B, 8'hFF);
    t_add(8'h00, 8'h00, 8'h00);
    t_refill(8'h21, 8'h17, 8'hB6);
    t_hold(8'hE7, 8'h5D);
    t_clear_copy(8'h9C);
    t_done_once();
    t_load_carry();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule